// File: doc/BRIEF.md
# Windowed Service Watchdog with Two-Byte Key

This block is a free-running watchdog counter driven by the oscillator clock. Software keeps it from firing by writing a two-byte key to a service port before the selected timeout runs out. If the count reaches the end of the period first, the block raises a reset request for the system reset logic. A malformed key is treated as a fault and also raises a reset request.

A 3-bit rate code selects one of seven power-of-two periods, or turns the watchdog off. In window mode, servicing is only legal in the last quarter of the period, and an early service attempt is a fault. Two halt-enable bits let the count freeze while the system sits in debug mode, or clear and stall while it sits in wait mode. The control bits are plain level inputs held by the surrounding register file. The key port is a one-cycle write strobe with a data byte. It has no back-pressure, because every write is consumed in the cycle it is presented.

Top module: `svc_watchdog`

## Requirements
- R1: The period P is 2^(L-EXP_REDUCE) clock cycles, with L = 14, 16, 18, 20, 22, 23, 24 for rate codes 1 to 7. After the rate code is applied (or changed), with no service and no halt, `rst_req` goes high after exactly P+1 rising edges.
- R2: Rate code 0 disables the watchdog. `rst_req` stays low and key writes are ignored, including invalid ones.
- R3: A valid service is a key write of 0x55 followed by a key write of 0xAA, with any number of idle cycles between them. It restarts the count, so the next timeout pulse follows exactly P rising edges after the edge that takes 0xAA.
- R4: A key write other than 0x55 when no 0x55 is pending, or other than 0xAA when one is pending, is a fault. `rst_req` is high in the cycle after that write.
- R5: `rst_req` is a single-cycle pulse. The count is zero after it, so uninterrupted timeouts repeat every P cycles.
- R6: With `window_en` high, a key write while the count is below 3P/4 (top two count bits not both set) is a fault. From count 3P/4 upward, keys are accepted.
- R7: With `wait_halt_en` high, `wait_mode` high clears the count, discards a pending 0x55, ignores key writes and keeps `rst_req` low. After release, the timeout follows exactly P edges later.
- R8: With `debug_halt_en` high, `debug_mode` high holds the count and ignores key writes. After release, counting resumes from the held value.
- R9: With its halt-enable bit low, `wait_mode` or `debug_mode` has no effect on the timeout.
- R10: A change of `rate_sel` restarts the count from zero. Key writes in the cycle of the change are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_sel | input | 3 | Timeout code, 0 = off |
| window_en | input | 1 | Reject service in first 3/4 of period |
| wait_halt_en | input | 1 | Clear and stall in wait mode |
| debug_halt_en | input | 1 | Hold count in debug mode |
| wait_mode | input | 1 | System is in wait mode |
| debug_mode | input | 1 | System is in active debug mode |
| key_wr | input | 1 | Service key write strobe |
| key_data | input | 8 | Service key byte |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The hardest case to reach is the exact window boundary. The key has to land when the count is one below 3P/4, and again when it equals 3P/4. The stimulus first performs a valid service so the count is known to be zero. It then idles a counted number of cycles before writing the key, so the count seen by the write is set arithmetically. A reduced period exponent keeps all seven rate codes short enough to sweep, and each one is checked for both the first and the repeated timeout.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] KEY_OPEN  = 8'h55;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;

  // log2 of the timeout period for a rate code, lowered by reduce
  function automatic logic [4:0] period_log2(input logic [2:0] rate, input int unsigned reduce);
    int unsigned e;
    case (rate)
      3'd1: e = 14;
      3'd2: e = 16;
      3'd3: e = 18;
      3'd4: e = 20;
      3'd5: e = 22;
      3'd6: e = 23;
      default: e = 24;
    endcase
    return 5'(e - reduce);
  endfunction
endpackage

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int unsigned CW     = 24,
  parameter int unsigned REDUCE = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    rate,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          terminal,
  output logic          late
);
  import wdt_pkg::*;

  logic [4:0]    lg;
  logic [CW-1:0] last;

  always_comb begin
    lg       = period_log2(rate, REDUCE);
    last     = (CW'(1) << lg) - CW'(1);
    terminal = (cnt == last);
    // last quarter: upper two bits of the period-wide count both set
    late     = ((cnt >> (lg - 5'd2)) == CW'(3));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/wdt_key.sv
module wdt_key (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_arm,
  input  logic       ev,
  input  logic [7:0] data,
  input  logic       early,
  output logic       service,
  output logic       fault
);
  import wdt_pkg::*;

  logic armed_q;
  logic open_ok, close_ok;

  always_comb begin
    open_ok  = ev && !early && !armed_q && (data == KEY_OPEN);
    close_ok = ev && !early &&  armed_q && (data == KEY_CLOSE);
    service  = close_ok;
    fault    = ev && !open_ok && !close_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          armed_q <= 1'b0;
    else if (clr_arm || fault || service) armed_q <= 1'b0;
    else if (open_ok)                    armed_q <= 1'b1;
  end
endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog #(
  parameter int unsigned EXP_REDUCE = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] rate_sel,
  input  logic       window_en,
  input  logic       wait_halt_en,
  input  logic       debug_halt_en,
  input  logic       wait_mode,
  input  logic       debug_mode,
  input  logic       key_wr,
  input  logic [7:0] key_data,
  output logic       rst_req
);
  localparam int unsigned CNT_W = 24 - EXP_REDUCE;

  logic [2:0]       rate_q;
  logic [CNT_W-1:0] cnt_q;
  logic enabled, rate_chg, wait_hold, dbg_hold, active;
  logic terminal, late, service, fault, timeout, trip;

  always_comb begin
    enabled   = (rate_sel != 3'd0);
    rate_chg  = (rate_sel != rate_q);
    wait_hold = wait_halt_en && wait_mode;
    dbg_hold  = debug_halt_en && debug_mode && !wait_hold;
    active    = enabled && !rate_chg && !wait_hold && !dbg_hold;
    timeout   = active && terminal && !service;
    trip      = fault || timeout;
  end

  wdt_count #(.CW(CNT_W), .REDUCE(EXP_REDUCE)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate     (rate_sel),
    .clr      (trip || service || wait_hold || rate_chg || !enabled),
    .inc      (active),
    .cnt      (cnt_q),
    .terminal (terminal),
    .late     (late)
  );

  wdt_key u_key (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_arm (trip || wait_hold || rate_chg || !enabled),
    .ev      (active && key_wr),
    .data    (key_data),
    .early   (window_en && !late),
    .service (service),
    .fault   (fault)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q  <= 3'd0;
      rst_req <= 1'b0;
    end else begin
      rate_q  <= rate_sel;
      rst_req <= trip;
    end
  end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int unsigned CW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    rate_sel,
  input logic          wait_halt_en,
  input logic          debug_halt_en,
  input logic          wait_mode,
  input logic          debug_mode,
  input logic          key_wr,
  input logic [7:0]    key_data,
  input logic          rst_req,
  input logic [CW-1:0] cnt
);
  logic running;
  assign running = (rate_sel != 3'd0) && !(wait_halt_en && wait_mode) &&
                   !(debug_halt_en && debug_mode);

  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 3'd0) |=> !rst_req);

  a_r4_bad_key_trips: assert property (@(posedge clk) disable iff (!rst_n)
    (running && rate_sel == $past(rate_sel) && key_wr &&
     key_data != 8'h55 && key_data != 8'hAA) |=> rst_req);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && !key_wr) |=> !rst_req);

  a_r5_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (cnt == '0));

  a_r7_wait_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_halt_en && wait_mode) |=> (!rst_req && cnt == '0));

  a_r8_debug_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (debug_halt_en && debug_mode && !(wait_halt_en && wait_mode) &&
     rate_sel != 3'd0 && rate_sel == $past(rate_sel)) |=> $stable(cnt));
endmodule

bind svc_watchdog wdt_checker #(.CW(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rate_sel      (rate_sel),
  .wait_halt_en  (wait_halt_en),
  .debug_halt_en (debug_halt_en),
  .wait_mode     (wait_mode),
  .debug_mode    (debug_mode),
  .key_wr        (key_wr),
  .key_data      (key_data),
  .rst_req       (rst_req),
  .cnt           (cnt_q)
);

// File: tb/tb_svc_watchdog.sv
`timescale 1ns/1ps
module tb_svc_watchdog;
  localparam int unsigned RED = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] rate_sel = 3'd0;
  logic window_en = 1'b0, wait_halt_en = 1'b0, debug_halt_en = 1'b0;
  logic wait_mode = 1'b0, debug_mode = 1'b0, key_wr = 1'b0;
  logic [7:0] key_data = 8'h00;
  logic rst_req;

  int checks = 0;
  int errors = 0;

  svc_watchdog #(.EXP_REDUCE(RED)) dut (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .window_en(window_en),
    .wait_halt_en(wait_halt_en), .debug_halt_en(debug_halt_en),
    .wait_mode(wait_mode), .debug_mode(debug_mode),
    .key_wr(key_wr), .key_data(key_data), .rst_req(rst_req)
  );

  always #2.5 clk = ~clk;

  function automatic int period(input int r);
    int e;
    case (r)
      1: e = 14; 2: e = 16; 3: e = 18; 4: e = 20;
      5: e = 22; 6: e = 23; default: e = 24;
    endcase
    return 1 << (e - RED);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // count rising edges until rst_req is seen high at a falling edge
  task automatic measure(input string req, input int exp);
    int n = 0;
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (rst_req) break;
    end
    check(req, n, exp);
  endtask

  task automatic key_write(input logic [7:0] d);
    key_wr = 1'b1; key_data = d;
    @(posedge clk); @(negedge clk);
    key_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet(input string req, input int n);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      if (rst_req) hits++;
    end
    check(req, hits, 0);
  endtask

  task automatic serve();
    key_write(8'h55);
    key_write(8'hAA);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("reset", rst_req, 0);
    rst_n = 1'b1;

    // R2: disabled, bad key ignored
    quiet("R2 disabled idle", 100);
    key_write(8'h12);
    check("R2 bad key ignored", rst_req, 0);

    // R1, R5: sweep every rate code
    for (int r = 1; r <= 7; r++) begin
      rate_sel = 3'(r);
      measure("R1 first timeout", period(r) + 1);
      @(posedge clk); @(negedge clk);
      check("R5 single pulse", rst_req, 0);
      measure("R5 repeat interval", period(r) - 1);
    end

    // R10: rate change restarts
    rate_sel = 3'd1;
    measure("R10 settle", period(1) + 1);
    idle(8);
    rate_sel = 3'd2;
    measure("R10 restart after change", period(2) + 1);
    rate_sel = 3'd1;
    measure("R10 settle back", period(1) + 1);

    // R3: valid service, with idle gap between bytes
    serve();
    check("R3 no pulse on service", rst_req, 0);
    measure("R3 timeout after service", period(1));
    key_write(8'h55); idle(3); key_write(8'hAA);
    measure("R3 gapped service", period(1));

    // R4: bad keys
    key_write(8'h12);
    check("R4 wrong byte", rst_req, 1);
    key_write(8'hAA);
    check("R4 close without open", rst_req, 1);
    key_write(8'h55);
    check("R4 open accepted", rst_req, 0);
    key_write(8'h55);
    check("R4 double open", rst_req, 1);
    key_write(8'h55); key_write(8'h00);
    check("R4 wrong close", rst_req, 1);

    // R6: window boundary at 3P/4 = 12 for P = 16
    serve();
    window_en = 1'b1;
    idle(period(1) * 3 / 4 - 1);
    key_write(8'h55);
    check("R6 early key faults", rst_req, 1);
    idle(period(1) * 3 / 4);
    key_write(8'h55);
    check("R6 open at boundary", rst_req, 0);
    key_write(8'hAA);
    check("R6 close in window", rst_req, 0);
    measure("R6 timeout after windowed service", period(1));
    window_en = 1'b0;

    // R7: wait halt
    wait_halt_en = 1'b1;
    serve(); idle(5);
    wait_mode = 1'b1;
    quiet("R7 wait holds", 100);
    key_write(8'h12);
    check("R7 key ignored in wait", rst_req, 0);
    wait_mode = 1'b0;
    measure("R7 timeout after wait", period(1));
    wait_halt_en = 1'b0;

    // R9: wait without enable
    serve();
    wait_mode = 1'b1;
    measure("R9 wait no effect", period(1));
    wait_mode = 1'b0;

    // R8: debug halt holds count at 5
    debug_halt_en = 1'b1;
    serve(); idle(5);
    debug_mode = 1'b1;
    quiet("R8 debug holds", 200);
    key_write(8'h12);
    check("R8 key ignored in debug", rst_req, 0);
    debug_mode = 1'b0;
    measure("R8 resume from held count", period(1) - 5);
    debug_halt_en = 1'b0;

    // R9: debug without enable
    serve();
    debug_mode = 1'b1;
    measure("R9 debug no effect", period(1));
    debug_mode = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule